// File: doc/BRIEF.md
# One-Position Shift and Rotate Unit

This block moves a data word by at most one bit position, left or right, and either drops the bit that leaves the word (filling the freed end with zero) or feeds it back in at the opposite end. A three-bit control word picks the operation. The block is purely combinational: the output follows the data and the control within the same cycle, with no clock and no storage.

Each output bit comes from its own four-way selector, which takes the bit in the same position, the bit from the next lower position or the bit from the next higher position. The two upper control bits steer every one of these selectors. At the two ends of the word a neighbour does not exist, so a pair of two-way selectors supplies the incoming bit there. The lowest control bit drives these, and chooses either a constant zero or the bit that wraps around from the far end. The width is a parameter with a default of four bits.

Top module: `shrot_unit`

## Requirements
- R1: With control[2:1] = 00 (codes 000 and 001) the output equals the input word for every input value.
- R2: With control[2:1] = 01 (codes 010 and 011, reserved) the output equals the input word for every input value.
- R3: With control = 100 the output is the input moved up by one position: out[i] = in[i-1] for i >= 1, and out[0] = 0.
- R4: With control = 101 the output is the input rotated up by one position: out[i] = in[i-1] for i >= 1, and out[0] = in[WIDTH-1].
- R5: With control = 110 the output is the input moved down by one position: out[i] = in[i+1] for i < WIDTH-1, and out[WIDTH-1] = 0.
- R6: With control = 111 the output is the input rotated down by one position: out[i] = in[i+1] for i < WIDTH-1, and out[WIDTH-1] = in[0].
- R7: The output depends on the present inputs alone: a change of data or control appears at the output without any clock edge, and no earlier input leaves a trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be shifted or rotated |
| ctrl_i | input | 3 | Operation code; bit 2 enables movement, bit 1 picks down (1) or up (0), bit 0 picks wrap (1) or zero fill (0) |
| data_o | output | WIDTH | Shifted, rotated or unchanged word |

## Verification
The assertions check, whenever the inputs settle, that the pass and reserved codes leave the word untouched, that a zero enters the freed end on a plain shift, and that a rotation keeps the count of ones. The exact placement of every bit under each code, and the absence of any memory from one input to the next, are shown only by the bench's exhaustive sweep of all codes and all data values and by its changes of input between clock edges.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int CTRL_W = 3;

  // Per-bit selector source
  typedef enum logic [1:0] {
    SRC_SELF   = 2'b00,
    SRC_SELF_R = 2'b01,
    SRC_LOWER  = 2'b10,
    SRC_UPPER  = 2'b11
  } lane_src_e;

  // Edge fill: zero for plain shift, wrapped bit for rotation
  function automatic logic edge_fill(input logic wrap_en, input logic wrapped_bit);
    return wrap_en ? wrapped_bit : 1'b0;
  endfunction

  // Four-way pick between the bit itself and its neighbours
  function automatic logic lane_pick(input lane_src_e src, input logic self_b,
                                     input logic lower_b, input logic upper_b);
    logic r;
    case (src)
      SRC_LOWER: r = lower_b;
      SRC_UPPER: r = upper_b;
      default:   r = self_b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/shrot_ctrl_dec.sv
module shrot_ctrl_dec
  import shrot_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output lane_src_e         src_o,
  output logic              wrap_o
);

  always_comb begin
    src_o  = lane_src_e'(ctrl_i[2:1]);
    wrap_o = ctrl_i[0];
  end

endmodule

// File: rtl/shrot_edge.sv
module shrot_edge
  import shrot_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             wrap_i,
  output logic             fill_lo_o,
  output logic             fill_hi_o
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    fill_lo_o = edge_fill(wrap_i, data_i[MSB]);
    fill_hi_o = edge_fill(wrap_i, data_i[0]);
  end

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
(
  input  lane_src_e src_i,
  input  logic      self_i,
  input  logic      lower_i,
  input  logic      upper_i,
  output logic      bit_o
);

  always_comb bit_o = lane_pick(src_i, self_i, lower_i, upper_i);

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  data_o
);

  localparam int MSB = WIDTH - 1;

  lane_src_e lane_src;
  logic      wrap_en;
  logic      fill_lo;
  logic      fill_hi;
  logic [WIDTH-1:0] lower_nb;
  logic [WIDTH-1:0] upper_nb;

  shrot_ctrl_dec u_dec (
    .ctrl_i (ctrl_i),
    .src_o  (lane_src),
    .wrap_o (wrap_en)
  );

  shrot_edge #(.WIDTH(WIDTH)) u_edge (
    .data_i    (data_i),
    .wrap_i    (wrap_en),
    .fill_lo_o (fill_lo),
    .fill_hi_o (fill_hi)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      if (i == 0) begin : g_lo_end
        assign lower_nb[i] = fill_lo;
      end else begin : g_lo_mid
        assign lower_nb[i] = data_i[i-1];
      end
      if (i == MSB) begin : g_hi_end
        assign upper_nb[i] = fill_hi;
      end else begin : g_hi_mid
        assign upper_nb[i] = data_i[i+1];
      end
      shrot_lane u_lane (
        .src_i   (lane_src),
        .self_i  (data_i[i]),
        .lower_i (lower_nb[i]),
        .upper_i (upper_nb[i]),
        .bit_o   (data_o[i])
      );
    end
  endgenerate

  // Checks on settled values; skipped while any input is unknown
  always_comb begin
    if (!$isunknown({data_i, ctrl_i})) begin
      if (ctrl_i[2:1] == 2'b00)
        assert_pass_R1: assert (data_o == data_i);
      if (ctrl_i[2:1] == 2'b01)
        assert_reserved_pass_R2: assert (data_o == data_i);
      if (ctrl_i == 3'b100)
        assert_shl_zero_fill_R3: assert (data_o[0] == 1'b0);
      if (ctrl_i == 3'b101)
        assert_rol_keeps_ones_R4: assert ($countones(data_o) == $countones(data_i));
      if (ctrl_i == 3'b110)
        assert_shr_zero_fill_R5: assert (data_o[MSB] == 1'b0);
      if (ctrl_i == 3'b111)
        assert_ror_keeps_ones_R6: assert ($countones(data_o) == $countones(data_i));
    end
  end

endmodule

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [2:0]   ctl = '0;
  logic [W-1:0] dout;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  shrot_unit #(.WIDTH(W)) dut_i (
    .data_i (din),
    .ctrl_i (ctl),
    .data_o (dout)
  );

  // Behavioural model using integer arithmetic
  function automatic int model(int v, int c);
    int r;
    case (c)
      4: r = (v * 2) % N;
      5: r = ((v * 2) % N) + (v / (N / 2));
      6: r = v / 2;
      7: r = (v / 2) + ((v % 2) * (N / 2));
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic string req_of(int c);
    case (c)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int exp);
    tests++;
    if (int'(dout) != exp) begin
      fails++;
      $display("FAIL %s ctrl=%0d data=%0d actual=%0d expected=%0d", req, ctl, din, dout, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // Output during reset with zero inputs (R1)
    @(negedge clk);
    check("R1", 0);
    @(posedge clk); #1 rst = 1'b0;

    // Exhaustive sweep: R1..R6 including reserved codes
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < N; v++) begin
        @(posedge clk); #1;
        ctl = 3'(c);
        din = W'(v);
        @(negedge clk);
        check(req_of(c), model(v, c));
      end
    end

    // R7: changes between edges appear without a clock, no history kept
    @(posedge clk); #1;
    ctl = 3'b101; din = 4'b1000;
    #1 check("R7", model(8, 5));
    din = 4'b0001;
    #1 check("R7", model(1, 5));
    ctl = 3'b111;
    #1 check("R7", model(1, 7));
    ctl = 3'b110;
    #1 check("R7", model(1, 6));
    ctl = 3'b011; din = 4'b1010;
    #1 check("R7", 10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule